// File: doc/BRIEF.md
# Counted Instruction Prefetch Queue Engine

This block collects counted instruction-prefetch hints from several hardware thread contexts and turns each one into a run of cache-line prefetch requests toward the next memory level. A hint carries a byte start address and a line count. It is captured when the prefetch operation reaches the execute stage, and it waits in a FIFO that belongs to the issuing thread. The head entry of every non-empty FIFO is expanded one line at a time. Its address advances by one line, 64 bytes by default, on each line issued, and the entry leaves the FIFO after its last line.

The memory side tells the engine each cycle which of its issue slots are free. Counted prefetches have the lowest memory priority, below demand fetches and below next-line or streaming prefetches. Only slots that all of those higher-priority sources left unused are offered here. The engine fills the offered slots from the thread queues in round-robin order. Hints are only advice, so a hint that arrives at a full queue is dropped without notice. A hint with a count of zero is dropped as well. A per-thread flush empties a queue when its helper thread is terminated.

Top module: `cpf_engine`

## Requirements
- R1: While rst_ni is low, and after reset until a hint has been accepted, no bit of pf_valid_o is set.
- R2: An accepted hint with count N (1 to 2^CNT_W-1, so 1..63 by default) produces exactly N requests. Request k (k = 0..N-1) has the address (start & ~(LINE_BYTES-1)) + k*LINE_BYTES, modulo 2^ADDR_W. The requests leave in increasing k.
- R3: A hint whose line count is zero is ignored: it issues no request and takes no queue entry.
- R4: Each thread queue holds DEPTH (64) hints. A hint that arrives while the queue holds DEPTH entries is discarded. Fullness is judged on the occupancy at the start of the cycle, so a pop in that same cycle does not make room.
- R5: A request is presented only on a slot s whose slot_free_i[s] is 1. The granted lines fill the free slots in ascending slot index, so at most ISSUE_W lines go out per cycle.
- R6: A thread gets at most one line per cycle, and the two slots of one cycle always carry different pf_tid_o values. Threads are scanned round-robin from a pointer that skips empty queues. The pointer starts at thread 0 after reset and moves to one past the last thread served.
- R7: While flush_i[t] is high, thread t presents no request. The flush empties t's queue. A hint to t in the same cycle is discarded.
- R8: Hints from one thread are expanded strictly in arrival order. All lines of one hint go out before any line of the next.
- R9: A hint accepted at a clock edge can present its first line in the cycle that follows that edge. There is no bypass in the cycle in which the hint is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hint_valid_i | input | NT | Per-thread hint strobe from the execute stage |
| hint_addr_i | input | NT*ADDR_W | Per-thread hint start byte address |
| hint_lines_i | input | NT*CNT_W | Per-thread hint line count |
| flush_i | input | NT | Per-thread queue flush on helper termination |
| slot_free_i | input | ISSUE_W | Issue slots left unused by higher-priority traffic this cycle |
| pf_valid_o | output | ISSUE_W | Line request present on slot |
| pf_addr_o | output | ISSUE_W*ADDR_W | Line-aligned request address per slot |
| pf_tid_o | output | ISSUE_W*TID_W | Thread that owns each slot's request |

## Verification
The bench builds the block with its defaults: four threads, two issue slots, 64-entry queues, a 6-bit count and 64-byte lines. A 64-entry queue is filled in 64 cycles while the slots are held closed. That makes the full-queue drop, and the drop when a pop falls in the same cycle, quick to reach. The 6-bit count puts the 63-line maximum expansion in reach, and a start address near the top of the 32-bit space exercises the address wrap. With four threads and two slots, the round-robin order can be checked with every queue busy, with some queues empty, and with only the upper slot free.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  // Increment with wrap at n, for pointers whose range is not a power of two.
  function automatic int unsigned cpf_wrap_inc(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/cpf_hint_queue.sv
module cpf_hint_queue #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 6,
  parameter int DEPTH      = 64,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [CNT_W-1:0]  push_lines_i,
  input  logic              flush_i,
  input  logic              take_i,
  output logic              avail_o,
  output logic [ADDR_W-1:0] line_addr_o,
  output logic [OCC_W-1:0]  occ_o
);
  logic [ADDR_W-1:0] base_q  [DEPTH];
  logic [CNT_W-1:0]  lines_q [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q;
  logic [OCC_W-1:0]  occ_q;
  logic [CNT_W-1:0]  idx_q;
  logic full, accept, last, pop, step;

  assign full    = (occ_q == OCC_W'(DEPTH));
  assign avail_o = (occ_q != '0);
  assign accept  = push_i && (push_lines_i != '0) && !full && !flush_i;
  assign last    = ((idx_q + CNT_W'(1)) == lines_q[rd_q]);
  assign step    = take_i && avail_o && !flush_i;
  assign pop     = step && last;
  assign occ_o   = occ_q;

  assign line_addr_o = (base_q[rd_q] & ~ADDR_W'(LINE_BYTES - 1))
                     + (ADDR_W'(idx_q) << OFF_W);

  function automatic logic [PTR_W-1:0] inc_ptr(logic [PTR_W-1:0] p);
    return PTR_W'(cpf_pkg::cpf_wrap_inc(int'(p), DEPTH));
  endfunction

  always_ff @(posedge clk_i) begin
    if (accept) begin
      base_q[wr_q]  <= push_addr_i;
      lines_q[wr_q] <= push_lines_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      occ_q <= '0;
      idx_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      occ_q <= '0;
      idx_q <= '0;
    end else begin
      if (accept) wr_q <= inc_ptr(wr_q);
      if (pop)    rd_q <= inc_ptr(rd_q);
      unique case ({accept, pop})
        2'b10:   occ_q <= occ_q + OCC_W'(1);
        2'b01:   occ_q <= occ_q - OCC_W'(1);
        default: occ_q <= occ_q;
      endcase
      if (step) idx_q <= last ? '0 : idx_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cpf_rr_pick.sv
module cpf_rr_pick #(
  parameter int NT    = 4,
  parameter int NPICK = 2,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1,
  localparam int AV_W  = $clog2(NPICK + 1)
) (
  input  logic [NT-1:0]               req_i,
  input  logic [TID_W-1:0]            ptr_i,
  input  logic [AV_W-1:0]             n_avail_i,
  output logic [NT-1:0]               grant_o,
  output logic [NPICK-1:0]            pick_vld_o,
  output logic [NPICK-1:0][TID_W-1:0] pick_tid_o,
  output logic                        any_o,
  output logic [TID_W-1:0]            nxt_ptr_o
);
  always_comb begin
    int cnt;
    int lst;
    int idx;
    cnt        = 0;
    lst        = 0;
    grant_o    = '0;
    pick_vld_o = '0;
    pick_tid_o = '0;
    for (int i = 0; i < NT; i++) begin
      idx = int'(ptr_i) + i;
      if (idx >= NT) idx = idx - NT;
      for (int j = 0; j < NT; j++) begin
        if (j == idx && req_i[j] && cnt < int'(n_avail_i) && cnt < NPICK) begin
          grant_o[j] = 1'b1;
          for (int k = 0; k < NPICK; k++) begin
            if (k == cnt) begin
              pick_vld_o[k] = 1'b1;
              pick_tid_o[k] = TID_W'(j);
            end
          end
          lst = j;
          cnt = cnt + 1;
        end
      end
    end
    any_o     = (cnt != 0);
    nxt_ptr_o = TID_W'(cpf_pkg::cpf_wrap_inc(lst, NT));
  end
endmodule

// File: rtl/cpf_engine.sv
module cpf_engine #(
  parameter int NT         = 4,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 6,
  parameter int DEPTH      = 64,
  parameter int ISSUE_W    = 2,
  parameter int LINE_BYTES = 64,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1,
  localparam int AV_W  = $clog2(ISSUE_W + 1),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NT-1:0]                     hint_valid_i,
  input  logic [NT-1:0][ADDR_W-1:0]         hint_addr_i,
  input  logic [NT-1:0][CNT_W-1:0]          hint_lines_i,
  input  logic [NT-1:0]                     flush_i,
  input  logic [ISSUE_W-1:0]                slot_free_i,
  output logic [ISSUE_W-1:0]                pf_valid_o,
  output logic [ISSUE_W-1:0][ADDR_W-1:0]    pf_addr_o,
  output logic [ISSUE_W-1:0][TID_W-1:0]     pf_tid_o
);
  logic [NT-1:0]                  q_avail, q_req, q_grant;
  logic [NT-1:0][ADDR_W-1:0]      q_line;
  logic [NT-1:0][OCC_W-1:0]       q_occ;
  logic [ISSUE_W-1:0]             pick_vld;
  logic [ISSUE_W-1:0][TID_W-1:0]  pick_tid;
  logic [TID_W-1:0]               rr_q, rr_nxt;
  logic                           rr_any;
  logic [AV_W-1:0]                n_avail;

  for (genvar t = 0; t < NT; t++) begin : g_q
    cpf_hint_queue #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES)
    ) u_q (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (hint_valid_i[t]),
      .push_addr_i (hint_addr_i[t]),
      .push_lines_i(hint_lines_i[t]),
      .flush_i     (flush_i[t]),
      .take_i      (q_grant[t]),
      .avail_o     (q_avail[t]),
      .line_addr_o (q_line[t]),
      .occ_o       (q_occ[t])
    );
  end

  assign q_req   = q_avail & ~flush_i;
  assign n_avail = AV_W'($countones(slot_free_i));

  cpf_rr_pick #(.NT(NT), .NPICK(ISSUE_W)) u_pick (
    .req_i     (q_req),
    .ptr_i     (rr_q),
    .n_avail_i (n_avail),
    .grant_o   (q_grant),
    .pick_vld_o(pick_vld),
    .pick_tid_o(pick_tid),
    .any_o     (rr_any),
    .nxt_ptr_o (rr_nxt)
  );

  // k-th pick lands on the k-th free slot
  always_comb begin
    logic [AV_W-1:0] rank;
    rank       = '0;
    pf_valid_o = '0;
    pf_tid_o   = '0;
    pf_addr_o  = '0;
    for (int s = 0; s < ISSUE_W; s++) begin
      if (slot_free_i[s]) begin
        for (int k = 0; k < ISSUE_W; k++) begin
          if (rank == AV_W'(k) && pick_vld[k]) begin
            pf_valid_o[s] = 1'b1;
            pf_tid_o[s]   = pick_tid[k];
            for (int t = 0; t < NT; t++)
              if (pick_tid[k] == TID_W'(t)) pf_addr_o[s] = q_line[t];
          end
        end
        rank = rank + AV_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rr_q <= '0;
    else if (rr_any) rr_q <= rr_nxt;
  end
endmodule

// File: rtl/cpf_engine_chk.sv
module cpf_engine_chk #(
  parameter int NT      = 4,
  parameter int CNT_W   = 6,
  parameter int DEPTH   = 64,
  parameter int ISSUE_W = 2,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NT-1:0]                 hint_valid_i,
  input logic [NT-1:0][CNT_W-1:0]      hint_lines_i,
  input logic [NT-1:0]                 flush_i,
  input logic [ISSUE_W-1:0]            slot_free_i,
  input logic [ISSUE_W-1:0]            pf_valid_o,
  input logic [ISSUE_W-1:0][TID_W-1:0] pf_tid_o,
  input logic [NT-1:0][OCC_W-1:0]      q_occ
);
  always_comb begin
    if (!rst_ni) assert_reset_idle_R1: assert (pf_valid_o == '0);
  end

  for (genvar s = 0; s < ISSUE_W; s++) begin : g_s
    assert_slot_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pf_valid_o[s] |-> slot_free_i[s]);
    if (s > 0) begin : g_low
      assert_low_slot_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pf_valid_o[s] && slot_free_i[s-1]) |-> pf_valid_o[s-1]);
    end
    for (genvar s2 = s + 1; s2 < ISSUE_W; s2++) begin : g_pair
      assert_distinct_tid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pf_valid_o[s] && pf_valid_o[s2]) |-> (pf_tid_o[s] != pf_tid_o[s2]));
    end
    for (genvar t = 0; t < NT; t++) begin : g_t
      assert_flush_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flush_i[t] && pf_valid_o[s]) |-> (pf_tid_o[s] != TID_W'(t)));
      assert_flush_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i[t] |=> !(pf_valid_o[s] && pf_tid_o[s] == TID_W'(t)));
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_occ
    assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_occ[t] <= OCC_W'(DEPTH));
    assert_zero_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hint_valid_i[t] && hint_lines_i[t] == '0) |=> (q_occ[t] <= $past(q_occ[t])));
    assert_full_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_occ[t] == OCC_W'(DEPTH) && !flush_i[t] && !(|pf_valid_o))
        |=> (q_occ[t] == OCC_W'(DEPTH)));
  end
endmodule

bind cpf_engine cpf_engine_chk #(
  .NT(NT), .CNT_W(CNT_W), .DEPTH(DEPTH), .ISSUE_W(ISSUE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hint_valid_i(hint_valid_i),
  .hint_lines_i(hint_lines_i),
  .flush_i     (flush_i),
  .slot_free_i (slot_free_i),
  .pf_valid_o  (pf_valid_o),
  .pf_tid_o    (pf_tid_o),
  .q_occ       (q_occ)
);

// File: tb/sim_cpf_engine.sv
`timescale 1ns/1ps
module sim_cpf_engine;
  localparam int NT = 4, AW = 32, CW = 6, DEPTH = 64, IW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NT-1:0]          hv = '0;
  logic [NT-1:0][AW-1:0]  ha = '0;
  logic [NT-1:0][CW-1:0]  hl = '0;
  logic [NT-1:0]          fl = '0;
  logic [IW-1:0]          sf = '0;
  logic [IW-1:0]          pv;
  logic [IW-1:0][AW-1:0]  pa;
  logic [IW-1:0][1:0]     pt;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_en = 1'b1;
  logic [AW-1:0] exp_q [NT][$];

  always #10 clk = ~clk;

  cpf_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni), .hint_valid_i(hv), .hint_addr_i(ha),
    .hint_lines_i(hl), .flush_i(fl), .slot_free_i(sf),
    .pf_valid_o(pv), .pf_addr_o(pa), .pf_tid_o(pt)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int pending();
    int n = 0;
    for (int t = 0; t < NT; t++) n += exp_q[t].size();
    return n;
  endfunction

  // driver: stage a hint for the next edge and record the expected lines
  task automatic stage_hint(int t, logic [AW-1:0] a, int n, bit acc);
    hv[t] = 1'b1;
    ha[t] = a;
    hl[t] = CW'(n);
    if (acc)
      for (int k = 0; k < n; k++)
        exp_q[t].push_back((a & ~AW'(63)) + AW'(k * 64));
  endtask

  task automatic drain(int maxc, string req);
    int c = 0;
    while (pending() > 0 && c < maxc) begin
      tick();
      c++;
    end
    @(negedge clk);
    chk(pending() == 0, req, "lines left undelivered", pending(), 0);
    chk(pv == '0, req, "no request after drain", pv, 0);
    tick();
  endtask

  // monitor: compare every presented line against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && mon_en) begin
      for (int s = 0; s < IW; s++) begin
        if (pv[s]) begin
          chk(sf[s] == 1'b1, "R5", "request on busy slot", s, -1);
          if (exp_q[pt[s]].size() == 0) begin
            chk(1'b0, "R2", "unexpected line", pa[s], 0);
          end else begin
            logic [AW-1:0] e;
            e = exp_q[pt[s]].pop_front();
            chk(pa[s] == e, "R2/R8", "line address", pa[s], e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    sf = '1;
    repeat (3) @(negedge clk);
    chk(pv == '0, "R1", "valid during reset", pv, 0);
    #1 rst_ni = 1'b1;
    tick();
    @(negedge clk);
    chk(pv == '0, "R1", "valid after reset", pv, 0);
    tick();

    // R6: round robin with all queues busy
    sf = '0;
    for (int t = 0; t < NT; t++) stage_hint(t, AW'(32'h1000 * (t + 1)), 3, 1);
    tick();
    hv = '0;
    sf = 2'b11;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(pv == 2'b11, "R6", "both slots used", pv, 3);
      chk(pt[0] == ((c % 2 == 0) ? 0 : 2), "R6", "slot0 thread", pt[0], (c % 2 == 0) ? 0 : 2);
      chk(pt[1] == ((c % 2 == 0) ? 1 : 3), "R6", "slot1 thread", pt[1], (c % 2 == 0) ? 1 : 3);
      tick();
    end
    drain(4, "R2");

    // R5/R6: only upper slot free, empty queues skipped
    sf = '0;
    stage_hint(3, 32'h0000_3040, 2, 1);
    stage_hint(1, 32'h0000_5000, 2, 1);
    tick();
    hv = '0;
    sf = 2'b10;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(pv == 2'b10, "R5", "upper slot only", pv, 2);
      chk(pt[1] == ((c % 2 == 0) ? 1 : 3), "R6", "skip empty order", pt[1], (c % 2 == 0) ? 1 : 3);
      tick();
    end
    drain(4, "R5");

    // R9: first line in the cycle after acceptance
    sf = 2'b11;
    stage_hint(2, 32'h0000_1234, 1, 1);
    @(negedge clk);
    chk(pv == '0, "R9", "no bypass", pv, 0);
    tick();
    hv = '0;
    @(negedge clk);
    chk(pv[0] && pt[0] == 2, "R9", "first line thread", pt[0], 2);
    chk(pa[0] == 32'h0000_1200, "R9", "first line address", pa[0], 32'h1200);
    tick();
    drain(2, "R9");

    // R3: zero count ignored
    stage_hint(0, 32'h0000_8000, 0, 1);
    tick();
    hv = '0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(pv == '0, "R3", "zero-count hint issued", pv, 0);
      tick();
    end

    // R2: maximum count and address wrap
    stage_hint(1, 32'h0000_4010, 63, 1);
    stage_hint(3, 32'hFFFF_FFF0, 2, 1);
    tick();
    hv = '0;
    drain(70, "R2");

    // R8: two hints of one thread stay in order
    stage_hint(3, 32'h0002_0000, 2, 1);
    tick();
    stage_hint(3, 32'h0003_0000, 1, 1);
    tick();
    hv = '0;
    drain(6, "R8");

    // R4: full queue drops, also with a pop in the same cycle
    sf = '0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      stage_hint(0, AW'(32'h0010_0000 + i * 64), 1, i < DEPTH);
      tick();
    end
    sf = 2'b01;
    stage_hint(0, 32'h00AB_0000, 1, 0);
    tick();
    hv = '0;
    drain(DEPTH + 4, "R4");

    // R7: flush clears queue, concurrent hint dropped
    sf = '0;
    for (int i = 0; i < 3; i++) begin
      stage_hint(2, AW'(32'h0040_0000 + i * 256), 2, 0);
      tick();
    end
    hv = '0;
    fl[2] = 1'b1;
    sf = 2'b11;
    stage_hint(2, 32'h0050_0000, 2, 0);
    @(negedge clk);
    chk(pv == '0, "R7", "request during flush", pv, 0);
    tick();
    fl = '0;
    hv = '0;
    @(negedge clk);
    chk(pv == '0, "R7", "request after flush", pv, 0);
    tick();
    stage_hint(2, 32'h0060_0000, 2, 1);
    tick();
    hv = '0;
    drain(4, "R7");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule